// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block drives an 8-bit external memory bus that shares its pins between the low address byte and the data. It runs from the crystal-rate clock and splits time into bus periods of four clocks. In each period, an address-latch strobe is high for one and a half clocks. While it is high, the shared port drives the low address byte, which an external transparent latch captures on the strobe's falling edge. After that edge, the port carries data. Code fetches assert an active-low program-store enable. Data reads and data writes assert their own active-low strobes.

A core-side requester hands over one request at a time through a valid/ready handshake. A request gives a kind, a low address byte and, for writes, a data byte. The request waits in a single holding slot until the next period boundary, so that no strobe is ever cut short. Read and fetch data is captured on the falling clock edge just before the strobe rises. It is returned with a one-clock valid pulse. A latch-disable input holds the latch strobe high whenever no access is running.

Top module: `mbus_seq`

## Requirements
- R1: With `ale_off` low and no access, `ale` repeats every 4 clocks and is high for 1.5 clocks of each period: from the rising clock edge that opens the period until the falling edge in the middle of its second clock.
- R2: While `rst_n` is low, `ale` is high, `port_oe` is low, `psen_n`, `rd_n` and `wr_n` are high, and `rsp_valid` is low.
- R3: With `ale_off` high, `ale` stays high in every period that carries no access. In a period that carries an access, `ale` pulses exactly as in R1, so it is low for 2.5 clocks.
- R4: During the first two clocks of an access period, `port_oe` is high and `port_out` equals the request's address byte. `ale` falls while the address is still driven. A strobe only falls after the `ale` pulse of its own period.
- R5: During the last two clocks of a fetch or read period, `port_oe` is low. During the last two clocks of a write period, `port_oe` is high and `port_out` carries the write data.
- R6: The request kind is encoded as 2'b00 fetch, 2'b01 read and 2'b10 write. `psen_n` is low for exactly the last two clocks of a fetch period, `rd_n` for those of a read period, and `wr_n` for those of a write period. At most one strobe is low at any time.
- R7: For a fetch or read, `port_in` is sampled on the falling clock edge in the middle of the last clock of the period. `rsp_valid` is then high for exactly one clock, the first clock of the following period, with `rsp_data` holding the sampled byte. Responses come back in request order.
- R8: `req_ready` is high exactly when the holding slot is empty, and it goes low on the edge that accepts a request. An accepted request starts at the next period boundary and runs the full period. A strobe falls 2 clocks after the rising edge of `ale`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-rate clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale_off | input | 1 | Latch-disable control; holds `ale` high outside accesses |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Holding slot is empty |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write |
| req_addr | input | 8 | Low address byte |
| req_wdata | input | 8 | Write data byte |
| rsp_valid | output | 1 | One-clock pulse with read or fetch data |
| rsp_data | output | 8 | Returned byte |
| ale | output | 1 | Address-latch strobe |
| psen_n | output | 1 | Program-store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| port_out | output | 8 | Shared port drive value |
| port_oe | output | 1 | Shared port drive enable (0 = high impedance) |
| port_in | input | 8 | Shared port input value |

## Verification
The bound checker watches several rules on every clock edge:
- the pin state while reset is held;
- that only one strobe is active at a time;
- that the port is released while a fetch or read strobe is low;
- the single-clock response pulse;
- that `ale` stays high in idle periods when latch-disable is set;
- that each strobe falls only after an `ale` pulse.

Other properties can only be shown by the bench's scenarios:
- the exact 1.5-of-4 duty cycle of the strobe;
- the address byte captured by an external latch model on the falling edge of `ale`;
- the strobe lengths, counted in half-clocks;
- the data that a write leaves in the external memory and that a later read returns;
- the position of the response within the period.

// File: rtl/mbus_seq_pkg.sv
package mbus_seq_pkg;

    typedef enum logic [1:0] {
        MB_FETCH = 2'b00,
        MB_READ  = 2'b01,
        MB_WRITE = 2'b10,
        MB_RSVD  = 2'b11
    } mb_kind_e;

    localparam int MB_PERIOD = 4;

    function automatic logic kind_returns_data(input logic [1:0] kind);
        return (kind == MB_FETCH) || (kind == MB_READ);
    endfunction

endpackage

// File: rtl/mbus_phase_gen.sv
module mbus_phase_gen #(
    parameter int PHASES = 4,
    parameter int PH_W   = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic            last_ph
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } st_t;

    st_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (state_q.ph == PH_LAST) begin
            state_d.ph = '0;
        end else begin
            state_d.ph = state_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign phase   = state_q.ph;
    assign last_ph = (state_q.ph == PH_LAST);

endmodule

// File: rtl/mbus_req_slot.sv
module mbus_req_slot #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              last_ph,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [DATA_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              cur_vld,
    output logic [1:0]        cur_kind,
    output logic [DATA_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata
);
    typedef struct packed {
        logic              vld;
        logic [1:0]        kind;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } slot_t;

    typedef struct packed {
        slot_t pend;
        slot_t cur;
    } st_t;

    st_t  state_d, state_q;
    logic take;

    assign req_ready = !state_q.pend.vld;
    assign take      = req_valid && !state_q.pend.vld;

    always_comb begin
        state_d = state_q;
        // Period boundary: the held request becomes the running access.
        if (last_ph) begin
            state_d.cur      = state_q.pend;
            state_d.pend.vld = 1'b0;
        end
        // A new request is only parked; it never alters the running period.
        if (take) begin
            state_d.pend.vld   = 1'b1;
            state_d.pend.kind  = req_kind;
            state_d.pend.addr  = req_addr;
            state_d.pend.wdata = req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cur_vld   = state_q.cur.vld;
    assign cur_kind  = state_q.cur.kind;
    assign cur_addr  = state_q.cur.addr;
    assign cur_wdata = state_q.cur.wdata;

endmodule

// File: rtl/mbus_pin_ctl.sv
module mbus_pin_ctl
    import mbus_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PHASES = 4,
    parameter int PH_W   = $clog2(PHASES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_off,
    input  logic [PH_W-1:0]   phase,
    input  logic              last_ph,
    input  logic              cur_vld,
    input  logic [1:0]        cur_kind,
    input  logic [DATA_W-1:0] cur_addr,
    input  logic [DATA_W-1:0] cur_wdata,
    input  logic [DATA_W-1:0] port_in,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] port_out,
    output logic              port_oe,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int              ADDR_PHASES = PHASES / 2;
    localparam logic [PH_W-1:0] PH_DATA0    = PH_W'(ADDR_PHASES);
    localparam logic [PH_W-1:0] PH_LAST     = PH_W'(PHASES - 1);

    // Falling-edge state: second half of the latch pulse and read capture.
    typedef struct packed {
        logic              ale_tail;
        logic [DATA_W-1:0] cap;
    } neg_t;

    // Rising-edge state: response towards the requester.
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } pos_t;

    neg_t neg_d, neg_q;
    pos_t pos_d, pos_q;

    logic addr_ph;
    logic data_ph;
    logic is_write;
    logic wants_data;

    assign addr_ph    = cur_vld && (phase < PH_DATA0);
    assign data_ph    = cur_vld && (phase >= PH_DATA0);
    assign is_write   = (cur_kind == MB_WRITE);
    assign wants_data = kind_returns_data(cur_kind);

    always_comb begin
        neg_d          = neg_q;
        neg_d.ale_tail = (phase == '0);
        if (data_ph && wants_data && (phase == PH_LAST)) begin
            neg_d.cap = port_in;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            neg_q <= '0;
        end else begin
            neg_q <= neg_d;
        end
    end

    always_comb begin
        pos_d     = pos_q;
        pos_d.vld = last_ph && cur_vld && wants_data;
        if (pos_d.vld) begin
            pos_d.data = neg_q.cap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    // Pulse: whole first clock plus the first half of the second clock.
    assign ale = !rst_n
               || (ale_off && !cur_vld)
               || (phase == '0)
               || neg_q.ale_tail;

    assign port_oe  = rst_n && (addr_ph || (data_ph && is_write));
    assign port_out = addr_ph ? cur_addr
                    : ((data_ph && is_write) ? cur_wdata : '0);

    assign psen_n = !(data_ph && (cur_kind == MB_FETCH));
    assign rd_n   = !(data_ph && (cur_kind == MB_READ));
    assign wr_n   = !(data_ph && is_write);

    assign rsp_valid = pos_q.vld;
    assign rsp_data  = pos_q.data;

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq #(
    parameter int DATA_W = 8,
    parameter int PHASES = mbus_seq_pkg::MB_PERIOD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_off,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [DATA_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] port_out,
    output logic              port_oe,
    input  logic [DATA_W-1:0] port_in
);
    localparam int PH_W = $clog2(PHASES);

    logic [PH_W-1:0]   phase;
    logic              last_ph;
    logic              cur_vld;
    logic [1:0]        cur_kind;
    logic [DATA_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;

    mbus_phase_gen #(
        .PHASES (PHASES),
        .PH_W   (PH_W)
    ) phase_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .last_ph (last_ph)
    );

    mbus_req_slot #(
        .DATA_W (DATA_W)
    ) slot_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .last_ph   (last_ph),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cur_vld   (cur_vld),
        .cur_kind  (cur_kind),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata)
    );

    mbus_pin_ctl #(
        .DATA_W (DATA_W),
        .PHASES (PHASES),
        .PH_W   (PH_W)
    ) pins_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ale_off   (ale_off),
        .phase     (phase),
        .last_ph   (last_ph),
        .cur_vld   (cur_vld),
        .cur_kind  (cur_kind),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .port_in   (port_in),
        .ale       (ale),
        .psen_n    (psen_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .port_out  (port_out),
        .port_oe   (port_oe),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

endmodule

// File: rtl/mbus_seq_chk.sv
module mbus_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic ale_off,
    input logic ale,
    input logic psen_n,
    input logic rd_n,
    input logic wr_n,
    input logic port_oe,
    input logic rsp_valid
);
    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_PINS: assert (ale && !port_oe && psen_n && rd_n && wr_n && !rsp_valid); // R2
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!psen_n, !rd_n, !wr_n}) <= 1); // R6

    AST_PORT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (!psen_n || !rd_n) |-> !port_oe); // R5

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R7

    AST_ALE_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_off && psen_n && rd_n && wr_n && !port_oe) |-> ale); // R3

    AST_STROBE_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(psen_n) || $fell(rd_n) || $fell(wr_n)) |-> (!ale && $past(ale, 2))); // R4

endmodule

bind mbus_seq mbus_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ale_off   (ale_off),
    .ale       (ale),
    .psen_n    (psen_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .port_oe   (port_oe),
    .rsp_valid (rsp_valid)
);

// File: tb/mbus_seq_tb.sv
module mbus_seq_tb_top;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ale_off = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_kind = 2'b00;
    logic [7:0] req_addr = 8'h00;
    logic [7:0] req_wdata = 8'h00;
    logic       rsp_valid;
    logic [7:0] rsp_data;
    logic       ale, psen_n, rd_n, wr_n, port_oe;
    logic [7:0] port_out;
    logic [7:0] port_in;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] dmem    [256];
    logic [7:0] exp_mem [256];
    logic [7:0] lat_addr = 8'h00;
    logic [7:0] rsp_q  [$];
    logic [7:0] addr_q [$];

    int hi_cnt, lo_cnt, rise_cnt, psen_lo, rd_lo, wr_lo;
    int since_rise = 0;
    logic prev_ale = 1'b1, prev_psen = 1'b1, prev_rd = 1'b1, prev_wr = 1'b1;

    always #(CLK_P/2) clk = !clk;

    mbus_seq dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ale_off   (ale_off),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .ale       (ale),
        .psen_n    (psen_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .port_out  (port_out),
        .port_oe   (port_oe),
        .port_in   (port_in)
    );

    function automatic logic [7:0] code_of(input logic [7:0] a);
        return a * 8'd7 + 8'd3;
    endfunction

    // External memory model on the shared port.
    assign port_in = !psen_n ? code_of(lat_addr) : (!rd_n ? dmem[lat_addr] : 8'h00);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // External address latch, transparent while ale is high.
    always @(negedge ale) begin
        if (rst_n && port_oe) begin
            lat_addr = port_out;
            if (addr_q.size() == 0) begin
                chk(0, "R4", "unexpected address phase", port_out, 0);
            end else begin
                logic [7:0] ea;
                ea = addr_q.pop_front();
                chk(port_out == ea, "R4", "latched address", port_out, ea);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !wr_n && port_oe) dmem[lat_addr] = port_out;
    end

    task automatic take_sample(input bit second);
        if (rst_n) begin
            if (ale) hi_cnt++; else lo_cnt++;
            if (ale && !prev_ale) begin
                rise_cnt++;
                since_rise = 0;
            end else begin
                since_rise++;
            end
            if (!psen_n) psen_lo++;
            if (!rd_n) rd_lo++;
            if (!wr_n) wr_lo++;
            if (!ale_off && ((!psen_n && prev_psen) || (!rd_n && prev_rd) || (!wr_n && prev_wr)))
                chk(since_rise == 4, "R8", "half-clocks from ale rise to strobe", since_rise, 4);
            if (!psen_n || !rd_n)
                chk(!port_oe, "R5", "port released in read data phase", port_oe, 0);
            if (!second && rsp_valid) begin
                if (rsp_q.size() == 0) begin
                    chk(0, "R7", "unexpected response", rsp_data, 0);
                end else begin
                    logic [7:0] ed;
                    ed = rsp_q.pop_front();
                    chk(rsp_data == ed, "R7", "response data", rsp_data, ed);
                end
                if (!ale_off)
                    chk(since_rise == 0, "R7", "response position in period", since_rise, 0);
            end
        end
        prev_ale = ale; prev_psen = psen_n; prev_rd = rd_n; prev_wr = wr_n;
    endtask

    initial begin
        forever begin
            @(posedge clk); #2; take_sample(1'b0);
            @(negedge clk); #2; take_sample(1'b1);
        end
    end

    task automatic clear_win();
        hi_cnt = 0; lo_cnt = 0; rise_cnt = 0; psen_lo = 0; rd_lo = 0; wr_lo = 0;
    endtask

    task automatic issue(input logic [1:0] kind, input logic [7:0] a, input logic [7:0] wd);
        @(posedge clk); #1;
        req_valid = 1'b1; req_kind = kind; req_addr = a; req_wdata = wd;
        while (1) begin
            @(negedge clk);
            if (req_ready) break;
        end
        addr_q.push_back(a);
        if (kind == 2'b10) exp_mem[a] = wd;
        else if (kind == 2'b00) rsp_q.push_back(code_of(a));
        else rsp_q.push_back(exp_mem[a]);
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk(!req_ready, "R8", "ready drops after accept", req_ready, 0);
    endtask

    task automatic drain();
        while (rsp_q.size() != 0 || addr_q.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        chk(0, "R8", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            dmem[i]    = 8'(i) ^ 8'h5A;
            exp_mem[i] = 8'(i) ^ 8'h5A;
        end
        repeat (3) @(negedge clk);
        // R2: pins during reset
        chk(ale == 1'b1, "R2", "ale in reset", ale, 1);
        chk(port_oe == 1'b0, "R2", "port_oe in reset", port_oe, 0);
        chk(psen_n && rd_n && wr_n, "R2", "strobes in reset", {psen_n, rd_n, wr_n}, 7);
        chk(rsp_valid == 1'b0, "R2", "rsp_valid in reset", rsp_valid, 0);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);

        // R1: free-running latch strobe
        #1; clear_win();
        repeat (16) @(posedge clk);
        #1;
        chk(hi_cnt == 12, "R1", "ale high half-clocks in 4 periods", hi_cnt, 12);
        chk(rise_cnt == 4, "R1", "ale rises in 4 periods", rise_cnt, 4);

        // Fetches, including back-to-back ones held in the slot (R4 R6 R7 R8)
        clear_win();
        issue(2'b00, 8'h12, 8'h00);
        issue(2'b00, 8'h34, 8'h00);
        issue(2'b00, 8'hFF, 8'h00);
        drain();
        chk(psen_lo == 12, "R6", "psen_n low half-clocks for 3 fetches", psen_lo, 12);
        chk(rd_lo == 0 && wr_lo == 0, "R6", "other strobes during fetches", rd_lo + wr_lo, 0);

        // Writes then reads back (R5 R6 R7)
        clear_win();
        issue(2'b10, 8'h40, 8'hC3);
        issue(2'b10, 8'h41, 8'h3C);
        issue(2'b01, 8'h40, 8'h00);
        issue(2'b01, 8'h41, 8'h00);
        issue(2'b01, 8'h80, 8'h00);
        drain();
        chk(wr_lo == 8, "R6", "wr_n low half-clocks for 2 writes", wr_lo, 8);
        chk(rd_lo == 12, "R6", "rd_n low half-clocks for 3 reads", rd_lo, 12);
        chk(psen_lo == 0, "R6", "psen_n during data accesses", psen_lo, 0);
        chk(dmem[8'h41] == 8'h3C, "R5", "write data at external memory", dmem[8'h41], 8'h3C);

        // Latch disable (R3)
        @(posedge clk); #1;
        ale_off = 1'b1;
        repeat (8) @(posedge clk);
        #1; clear_win();
        repeat (16) @(posedge clk);
        #1;
        chk(lo_cnt == 0, "R3", "ale low half-clocks while disabled and idle", lo_cnt, 0);
        clear_win();
        issue(2'b01, 8'h41, 8'h00);
        drain();
        chk(lo_cnt == 5, "R3", "ale low half-clocks for one access while disabled", lo_cnt, 5);
        chk(rd_lo == 4, "R3", "rd_n low half-clocks while disabled", rd_lo, 4);

        @(posedge clk); #1;
        ale_off = 1'b0;
        repeat (4) @(posedge clk);
        issue(2'b00, 8'h00, 8'h00);
        drain();
        chk(rsp_q.size() == 0, "R7", "responses outstanding", rsp_q.size(), 0);
        chk(addr_q.size() == 0, "R4", "address phases outstanding", addr_q.size(), 0);
        finish_run();
    end

endmodule